// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

The block compares two unsigned operands and says whether the first is less than, equal to or greater than the second. It is assembled from identical 4-bit slices. Each slice weighs its own pair of nibbles and defers to a result that comes in from a less significant slice only when its own nibbles match. The slices are chained serially, so the verdict ripples from the lowest nibble up to the highest one.

The top level groups `WIDTH / 4` slices, 12 bits by default. The relation inputs of the lowest slice are brought out to the ports. Tying them to "equal" gives a plain unsigned comparison. Driving them from another comparator extends the chain further. The block is purely combinational.

Top module: `mag_chain`

## Requirements
- R1: `rel_gt` is 1 when `a_val > b_val`, or when the operands are identical and `low_gt` is 1.
- R2: `rel_eq` is 1 only when the operands are identical and `low_eq` is 1. Otherwise it is 0, even for identical operands.
- R3: `rel_lt` is 1 when `a_val < b_val`, or when the operands are identical and `low_lt` is 1.
- R4: Equality needs every bit position to match. Operands that differ in exactly one bit, at any position, never give `rel_eq`.
- R5: The most significant differing bit decides the relation, whatever the lower bits hold. For example, 0x800 against 0x7FF gives greater.
- R6: A higher slice passes the lower slice's relation through only when its own nibbles are equal. A difference confined to the lowest nibble still decides the full result.
- R7: When exactly one of `low_lt`, `low_eq` and `low_gt` is 1, exactly one of `rel_lt`, `rel_eq` and `rel_gt` is 1.
- R8: With `low_eq`=1 and the other two low inputs at 0, the outputs equal native unsigned comparison for any operands. `WIDTH` must be a positive multiple of 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_val | input | WIDTH | first unsigned operand |
| b_val | input | WIDTH | second unsigned operand |
| low_lt | input | 1 | relation from a less significant stage: less |
| low_eq | input | 1 | relation from a less significant stage: equal |
| low_gt | input | 1 | relation from a less significant stage: greater |
| rel_lt | output | 1 | a_val below b_val |
| rel_eq | output | 1 | a_val equal to b_val |
| rel_gt | output | 1 | a_val above b_val |

## Verification
Two functions meet in every slice: the slice's own nibble decision and the pass-through of the incoming relation. Both are live whenever the low inputs carry something other than "equal".

The bench provokes the overlap by driving a conflicting low relation against operands that already differ, for example `low_lt` while `a_val` is larger. The output must follow the operands and ignore the low inputs. The bench also drives identical operands, where the output must follow the low inputs exactly. Single-bit-difference sweeps place the deciding nibble in each slice in turn.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

   typedef struct packed {
      logic lt;
      logic eq;
      logic gt;
   } cmp_rel_t;

   localparam cmp_rel_t REL_EQUAL = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};

   function automatic logic rel_is_onehot(input cmp_rel_t r);
      return (32'(r.lt) + 32'(r.eq) + 32'(r.gt)) == 32'd1;
   endfunction

endpackage

// File: rtl/mag_bit_cell.sv
module mag_bit_cell (
   input  logic a_bit,
   input  logic b_bit,
   output logic same,
   output logic above,
   output logic below
);
   always_comb begin
      same  = ~(a_bit ^ b_bit);
      above = a_bit & ~b_bit;
      below = ~a_bit & b_bit;
   end

   always_comb begin
      a_r4_cell_exclusive: assert (32'(same) + 32'(above) + 32'(below) == 32'd1)
         else $error("bit cell outcome not exclusive");
   end
endmodule

// File: rtl/mag_slice.sv
module mag_slice
   import mag_cmp_pkg::*;
#(
   parameter int SLICE_W = 4
) (
   input  logic [SLICE_W-1:0] a_nib,
   input  logic [SLICE_W-1:0] b_nib,
   input  cmp_rel_t           lo_rel,
   output cmp_rel_t           hi_rel
);
   generate
      if (SLICE_W < 1) begin : g_bad_width
         $error("SLICE_W must be at least 1");
      end
   endgenerate

   logic [SLICE_W-1:0] bit_same, bit_above, bit_below;
   logic [SLICE_W-1:0] upper_same;
   logic [SLICE_W-1:0] win_gt, win_lt;

   for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
      mag_bit_cell u_cell (
         .a_bit (a_nib[i]),
         .b_bit (b_nib[i]),
         .same  (bit_same[i]),
         .above (bit_above[i]),
         .below (bit_below[i])
      );
      if (i == SLICE_W - 1) begin : g_top
         assign upper_same[i] = 1'b1;
      end else begin : g_rest
         assign upper_same[i] = upper_same[i+1] & bit_same[i+1];
      end
      assign win_gt[i] = bit_above[i] & upper_same[i];
      assign win_lt[i] = bit_below[i] & upper_same[i];
   end

   logic nib_eq, nib_gt, nib_lt;

   always_comb begin
      nib_eq    = &bit_same;
      nib_gt    = |win_gt;
      nib_lt    = |win_lt;
      hi_rel.gt = nib_gt | (nib_eq & lo_rel.gt);
      hi_rel.eq = nib_eq & lo_rel.eq;
      hi_rel.lt = nib_lt | (nib_eq & lo_rel.lt);
   end

   always_comb begin
      a_r1_slice_gt: assert (!(a_nib > b_nib) || hi_rel.gt)
         else $error("slice missed greater");
      a_r3_slice_lt: assert (!(a_nib < b_nib) || hi_rel.lt)
         else $error("slice missed less");
      a_r2_slice_eq: assert (!hi_rel.eq || (a_nib == b_nib && lo_rel.eq))
         else $error("slice equal without cause");
      a_r7_slice_onehot: assert (!rel_is_onehot(lo_rel) || rel_is_onehot(hi_rel))
         else $error("slice relation not one-hot");
   end
endmodule

// File: rtl/mag_chain.sv
module mag_chain
   import mag_cmp_pkg::*;
#(
   parameter int WIDTH   = 12,
   parameter int SLICE_W = 4
) (
   input  logic [WIDTH-1:0] a_val,
   input  logic [WIDTH-1:0] b_val,
   input  logic             low_lt,
   input  logic             low_eq,
   input  logic             low_gt,
   output logic             rel_lt,
   output logic             rel_eq,
   output logic             rel_gt
);
   localparam int N_SLICE = WIDTH / SLICE_W;

   generate
      if (SLICE_W != 4) begin : g_bad_slice
         $error("slices are four bits wide");
      end
      if (WIDTH < SLICE_W || (WIDTH % SLICE_W) != 0) begin : g_bad_width
         $error("WIDTH must be a positive multiple of SLICE_W");
      end
   endgenerate

   cmp_rel_t link [N_SLICE+1];

   assign link[0] = '{lt: low_lt, eq: low_eq, gt: low_gt};

   for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
      mag_slice #(.SLICE_W(SLICE_W)) u_slice (
         .a_nib  (a_val[s*SLICE_W +: SLICE_W]),
         .b_nib  (b_val[s*SLICE_W +: SLICE_W]),
         .lo_rel (link[s]),
         .hi_rel (link[s+1])
      );
   end

   always_comb begin
      rel_lt = link[N_SLICE].lt;
      rel_eq = link[N_SLICE].eq;
      rel_gt = link[N_SLICE].gt;
   end

   always_comb begin
      a_r8_native_match: assert (!(low_eq && !low_lt && !low_gt) ||
                                 ({rel_lt, rel_eq, rel_gt} ==
                                  {a_val < b_val, a_val == b_val, a_val > b_val}))
         else $error("chain disagrees with unsigned compare");
      a_r5_msb_decides: assert (a_val == b_val || (rel_gt == (a_val > b_val)))
         else $error("differing operands misjudged");
   end
endmodule

// File: tb/test_mag_chain.sv
module test_mag_chain;
   localparam int CLK_P = 10;
   localparam int W = 12;

   logic clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic [W-1:0] a_val, b_val;
   logic low_lt, low_eq, low_gt;
   logic rel_lt, rel_eq, rel_gt;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   mag_chain #(.WIDTH(W), .SLICE_W(4)) i_mag_chain (
      .a_val(a_val), .b_val(b_val),
      .low_lt(low_lt), .low_eq(low_eq), .low_gt(low_gt),
      .rel_lt(rel_lt), .rel_eq(rel_eq), .rel_gt(rel_gt)
   );

   // vector: a, b, low {lt,eq,gt}, expected {lt,eq,gt}
   localparam int NV = 10;
   localparam logic [29:0] VEC [NV] = '{
      {12'h000, 12'h000, 3'b010, 3'b010},  // R2 equal zero
      {12'hFFF, 12'hFFF, 3'b010, 3'b010},  // R2 equal ones
      {12'h800, 12'h7FF, 3'b010, 3'b001},  // R5 msb wins
      {12'h7FF, 12'h800, 3'b010, 3'b100},  // R5 msb wins
      {12'h5A3, 12'h5A4, 3'b010, 3'b100},  // R6 low nibble decides
      {12'h5A4, 12'h5A3, 3'b010, 3'b001},  // R6 low nibble decides
      {12'h3C3, 12'h3C3, 3'b001, 3'b001},  // R1 pass greater
      {12'h3C3, 12'h3C3, 3'b100, 3'b100},  // R3 pass less
      {12'h3C3, 12'h3C3, 3'b000, 3'b000},  // R2 low_eq off
      {12'h901, 12'h900, 3'b100, 3'b001}   // R1 conflicting low ignored
   };

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] lo);
      @(negedge clk);
      a_val = a; b_val = b;
      {low_lt, low_eq, low_gt} = lo;
      #(CLK_P/4);
   endtask

   task automatic check(input string tag, input logic [2:0] exp);
      total++;
      if ({rel_lt, rel_eq, rel_gt} !== exp) begin
         bad++;
         $display("FAIL %s a=%h b=%h got=%b exp=%b", tag, a_val, b_val,
                  {rel_lt, rel_eq, rel_gt}, exp);
      end
   endtask

   function automatic logic [2:0] native(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [2:0] lo);
      if (a > b) return 3'b001;
      if (a < b) return 3'b100;
      return lo;
   endfunction

   initial begin
      a_val = '0; b_val = '0; {low_lt, low_eq, low_gt} = 3'b010;
      #(CLK_P/4);
      check("R2 initial equal", 3'b010);

      for (int v = 0; v < NV; v++) begin
         apply(VEC[v][29:18], VEC[v][17:6], VEC[v][5:3]);
         check("R1 R2 R3 R5 R6 table", VEC[v][2:0]);
      end

      // R4: single-bit differences at every position
      for (int k = 0; k < W; k++) begin
         logic [W-1:0] base;
         base = W'($urandom);
         apply(base, base ^ (W'(1) << k), 3'b010);
         check("R4 one bit differs", native(base, base ^ (W'(1) << k), 3'b010));
      end

      // R7: every one-hot low relation against random operands
      for (int j = 0; j < 60; j++) begin
         logic [W-1:0] a, b;
         logic [2:0] lo;
         a = W'($urandom);
         b = (j % 3 == 0) ? a : W'($urandom);
         lo = 3'b001 << (j % 3);
         apply(a, b, lo);
         check("R7 one-hot relation", native(a, b, lo));
      end

      // R8: random operands with equal low relation
      for (int j = 0; j < 400; j++) begin
         logic [W-1:0] a, b;
         a = W'($urandom);
         b = (j % 8 == 0) ? a : W'($urandom);
         apply(a, b, 3'b010);
         check("R8 native compare", native(a, b, 3'b010));
      end

      // R6: equal upper slices with conflicting low relation
      apply(12'hABC, 12'hABD, 3'b001);
      check("R6 lowest nibble beats low input", 3'b100);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule